// File: doc/BRIEF.md
# Edge-Triggered GPIO Bank with Interrupt and Wake-Up

This block is one bank of sixteen general-purpose pins with its own memory-mapped register set. Software picks each pin's direction. It drives output levels through a data register, and it can change single bits without a read-modify-write by writing to a set alias or a clear alias. Incoming pin levels pass through a synchronizer. Software can read them back, and they also feed an edge detector.

Each pin has a 2-bit trigger code. The code selects which transitions are recorded: rising, falling, both, or none. Level sensitivity is not offered. The codes for pins 0-7 sit in the first trigger word and the codes for pins 8-15 sit in the second. A recorded edge sets that pin's bit in a sticky pending register, and software clears the bit by writing a one to it. The bank interrupt is raised when a pending bit meets its interrupt-enable bit. A separate wake-up request is raised when a pending bit meets its wake-enable bit. Each enable register has its own set and clear aliases.

Top module: `gpio_edge_bank`

## Requirements
- R1: After synchronous reset all pins are inputs (direction reads 0xFFFF, `pin_oe` is 0) and output data is 0. The interrupt enables, wake enables, trigger words and pending bits are all 0, and `bank_irq` and `wake_req` are low.
- R2: The identification register at 0x00 is read-only. It returns the major revision in bits [7:4] and the minor revision in bits [3:0], and all other bits are zero. The defaults give 0x21.
- R3: In the direction register at 0x30, a 1 makes the pin an input and a 0 makes it an output, and `pin_oe` is the inverse of that register. The output data register at 0x24 drives `pin_out` directly.
- R4: A write to 0x28 sets every output data bit that is 1 in the write data. A write to 0x2C clears every output data bit that is 1 in the write data. Bits written as 0 keep their value.
- R5: The interrupt enable register (0x08) and the wake enable register (0x14) can each be loaded directly. Each also has a set alias and a clear alias with the same one-bit-per-pin meaning as R4: set at 0x0C and 0x18, clear at 0x10 and 0x1C.
- R6: Pin p's trigger code sits in the word at 0x34 for pins 0-7 and at 0x38 for pins 8-15. Within that word it occupies bits [2*(p mod 8)+1 : 2*(p mod 8)]. The codes are 00 none, 01 falling edge, 10 rising edge and 11 both edges. Only a transition that matches the code sets the pending bit. The upper 16 bits of each word are stored but have no effect.
- R7: The pin-level register at 0x20 returns `pin_in` after the two-flop synchronizer. A change on the pin becomes readable after the second rising clock edge, and not after the first.
- R8: In the pending register at 0x04, writing a 1 to a bit clears it and writing a 0 leaves it alone. Writing 0xFFFF clears every pending bit.
- R9: If a matching edge on a pin and a clearing write to that pin's pending bit fall in the same cycle, the bit stays set.
- R10: `bank_irq` is high exactly when some pin's pending bit and interrupt-enable bit are both set. A pending bit is recorded even while its enable is off.
- R11: `wake_req` is high exactly when some pin's pending bit and wake-enable bit are both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 8 | Register byte offset |
| bus_wr | input | 1 | Write strobe for the current cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| pin_in | input | 16 | Asynchronous pin levels |
| pin_out | output | 16 | Output data to the pads |
| pin_oe | output | 16 | Output enable per pin, 1 = driven |
| bank_irq | output | 1 | Bank interrupt |
| wake_req | output | 1 | Wake-up request |

## Verification
Two operations can land on the same pending bit in the same cycle: an edge recorded by the detector and a write-one-to-clear from software. The bench first makes pins 0 and 2 pending. It then drops pin 2, whose code is both edges. It times the clearing write of 0x0005 so that the write lands on the same clock edge where the detector registers that fall, which is the third edge after the pin change. The check passes only if bit 0 is cleared and bit 2 stays set, so the pending register reads 0x0004.

// File: rtl/gpio_edge_pkg.sv
// gpio_edge_pkg
// Holds the register offsets, the per-pin trigger code values and the
// update operations for the set/clear registers of the edge-triggered GPIO
// bank. Assumes a byte-addressed map with one 32-bit word per register.
package gpio_edge_pkg;

    localparam int ADDR_W        = 8;
    localparam int DATA_W        = 32;
    localparam int PINS_PER_TRIG = 8;

    localparam logic [ADDR_W-1:0] OFS_IDENT    = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_PEND     = 8'h04;
    localparam logic [ADDR_W-1:0] OFS_IRQ_EN   = 8'h08;
    localparam logic [ADDR_W-1:0] OFS_IRQ_SET  = 8'h0C;
    localparam logic [ADDR_W-1:0] OFS_IRQ_CLR  = 8'h10;
    localparam logic [ADDR_W-1:0] OFS_WAKE_EN  = 8'h14;
    localparam logic [ADDR_W-1:0] OFS_WAKE_SET = 8'h18;
    localparam logic [ADDR_W-1:0] OFS_WAKE_CLR = 8'h1C;
    localparam logic [ADDR_W-1:0] OFS_PIN_IN   = 8'h20;
    localparam logic [ADDR_W-1:0] OFS_DOUT     = 8'h24;
    localparam logic [ADDR_W-1:0] OFS_DOUT_SET = 8'h28;
    localparam logic [ADDR_W-1:0] OFS_DOUT_CLR = 8'h2C;
    localparam logic [ADDR_W-1:0] OFS_DIR      = 8'h30;
    localparam logic [ADDR_W-1:0] OFS_TRIG0    = 8'h34;

    // Trigger code of one pin
    typedef enum logic [1:0] {
        TRIG_NONE = 2'b00,
        TRIG_FALL = 2'b01,
        TRIG_RISE = 2'b10,
        TRIG_BOTH = 2'b11
    } trig_code_e;

    // Update operation applied to a set/clear register
    typedef enum logic [1:0] {
        UPD_HOLD = 2'b00,
        UPD_LOAD = 2'b01,
        UPD_SET  = 2'b10,
        UPD_CLR  = 2'b11
    } upd_op_e;

    // Byte offset of trigger word w
    function automatic logic [ADDR_W-1:0] trig_ofs(input int w);
        return OFS_TRIG0 + ADDR_W'(4 * w);
    endfunction

endpackage

// File: rtl/gpio_in_sync.sv
// gpio_in_sync
// Brings the asynchronous pin levels into the clock domain through a chain
// of STAGES flops, then keeps one further copy so that the edge detector can
// compare the current level with the level one cycle earlier.
// Assumes STAGES >= 2.
module gpio_in_sync #(
    parameter int WIDTH  = 16,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] raw,
    output logic [WIDTH-1:0] level,
    output logic [WIDTH-1:0] level_prev
);

    logic [STAGES-1:0][WIDTH-1:0] chain_q;
    logic [WIDTH-1:0]             prev_q;

    // Shift the raw levels through the synchronizer chain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q[0] <= raw;
            for (int s = 1; s < STAGES; s++) begin
                chain_q[s] <= chain_q[s-1];
            end
        end
    end

    // Keep the previous synchronized level for edge comparison
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= chain_q[STAGES-1];
    end

    assign level      = chain_q[STAGES-1];
    assign level_prev = prev_q;

endmodule

// File: rtl/gpio_edge_detect.sv
// gpio_edge_detect
// Purely combinational. For each pin it compares the current level with the
// previous one and flags an event when the transition matches that pin's
// 2-bit trigger code (none, falling, rising, both).
// Assumes that level and level_prev come from the same synchronized sampling.
module gpio_edge_detect
    import gpio_edge_pkg::*;
#(
    parameter int NUM_PINS = 16
) (
    input  logic [NUM_PINS-1:0]   level,
    input  logic [NUM_PINS-1:0]   level_prev,
    input  logic [2*NUM_PINS-1:0] trig_codes,
    output logic [NUM_PINS-1:0]   evt
);

    generate
        for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
            trig_code_e code;
            logic       rose;
            logic       fell;

            assign code = trig_code_e'(trig_codes[2*p +: 2]);
            assign rose = level[p] & ~level_prev[p];
            assign fell = ~level[p] & level_prev[p];

            // Select which transitions count for this pin
            always_comb begin
                case (code)
                    TRIG_FALL: evt[p] = fell;
                    TRIG_RISE: evt[p] = rose;
                    TRIG_BOTH: evt[p] = rose | fell;
                    default:   evt[p] = 1'b0;
                endcase
            end
        end
    endgenerate

endmodule

// File: rtl/gpio_setclr_reg.sv
// gpio_setclr_reg
// A one-bit-per-pin register that software can load whole or change by
// set or clear masks, so that it never needs a read-modify-write.
// Assumes at most one operation per cycle, as chosen by the address decoder.
module gpio_setclr_reg
    import gpio_edge_pkg::*;
#(
    parameter int               WIDTH   = 16,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  upd_op_e          op,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] q
);

    // Apply load, set-mask or clear-mask updates
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= RST_VAL;
        end else begin
            case (op)
                UPD_LOAD: q <= wdata;
                UPD_SET:  q <= q | wdata;
                UPD_CLR:  q <= q & ~wdata;
                default:  q <= q;
            endcase
        end
    end

endmodule

// File: rtl/gpio_edge_bank.sv
// gpio_edge_bank
// Top of the edge-triggered GPIO bank. It decodes register writes, holds the
// trigger words and the sticky pending register, muxes the read data, and
// forms the bank interrupt and the wake-up request.
// Assumes NUM_PINS is a multiple of PINS_PER_TRIG and no larger than 32, and
// a single-cycle write strobe with reads returned combinationally.
module gpio_edge_bank
    import gpio_edge_pkg::*;
#(
    parameter int         NUM_PINS    = 16,
    parameter int         SYNC_STAGES = 2,
    parameter logic [3:0] REV_MAJOR   = 4'h2,
    parameter logic [3:0] REV_MINOR   = 4'h1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_wr,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    input  logic [NUM_PINS-1:0] pin_in,
    output logic [NUM_PINS-1:0] pin_out,
    output logic [NUM_PINS-1:0] pin_oe,
    output logic                bank_irq,
    output logic                wake_req
);

    localparam int TRIG_WORDS = NUM_PINS / PINS_PER_TRIG;

    upd_op_e                           irq_op, wake_op, dout_op, dir_op;
    logic [NUM_PINS-1:0]               pend_clr;
    logic [NUM_PINS-1:0]               irq_en_q, wake_en_q, dout_q, dir_q;
    logic [NUM_PINS-1:0]               pend_q;
    logic [NUM_PINS-1:0]               pin_level, pin_level_prev, edge_evt;
    logic [TRIG_WORDS-1:0][DATA_W-1:0] trig_q;
    logic [2*NUM_PINS-1:0]             trig_codes;

    // Decode a write into per-register operations and the clear mask
    always_comb begin
        irq_op   = UPD_HOLD;
        wake_op  = UPD_HOLD;
        dout_op  = UPD_HOLD;
        dir_op   = UPD_HOLD;
        pend_clr = '0;
        if (bus_wr) begin
            case (bus_addr)
                OFS_PEND:     pend_clr = bus_wdata[NUM_PINS-1:0];
                OFS_IRQ_EN:   irq_op   = UPD_LOAD;
                OFS_IRQ_SET:  irq_op   = UPD_SET;
                OFS_IRQ_CLR:  irq_op   = UPD_CLR;
                OFS_WAKE_EN:  wake_op  = UPD_LOAD;
                OFS_WAKE_SET: wake_op  = UPD_SET;
                OFS_WAKE_CLR: wake_op  = UPD_CLR;
                OFS_DOUT:     dout_op  = UPD_LOAD;
                OFS_DOUT_SET: dout_op  = UPD_SET;
                OFS_DOUT_CLR: dout_op  = UPD_CLR;
                OFS_DIR:      dir_op   = UPD_LOAD;
                default: ;
            endcase
        end
    end

    gpio_setclr_reg #(.WIDTH(NUM_PINS), .RST_VAL('0)) irq_en_i (
        .clk(clk), .rst_n(rst_n), .op(irq_op),
        .wdata(bus_wdata[NUM_PINS-1:0]), .q(irq_en_q)
    );

    gpio_setclr_reg #(.WIDTH(NUM_PINS), .RST_VAL('0)) wake_en_i (
        .clk(clk), .rst_n(rst_n), .op(wake_op),
        .wdata(bus_wdata[NUM_PINS-1:0]), .q(wake_en_q)
    );

    gpio_setclr_reg #(.WIDTH(NUM_PINS), .RST_VAL('0)) dout_i (
        .clk(clk), .rst_n(rst_n), .op(dout_op),
        .wdata(bus_wdata[NUM_PINS-1:0]), .q(dout_q)
    );

    gpio_setclr_reg #(.WIDTH(NUM_PINS), .RST_VAL('1)) dir_i (
        .clk(clk), .rst_n(rst_n), .op(dir_op),
        .wdata(bus_wdata[NUM_PINS-1:0]), .q(dir_q)
    );

    // Store the trigger words written by software
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trig_q <= '0;
        end else begin
            for (int w = 0; w < TRIG_WORDS; w++) begin
                if (bus_wr && bus_addr == trig_ofs(w)) trig_q[w] <= bus_wdata;
            end
        end
    end

    // Gather each pin's 2-bit code from the low half of its trigger word
    always_comb begin
        for (int p = 0; p < NUM_PINS; p++) begin
            trig_codes[2*p +: 2] =
                trig_q[p / PINS_PER_TRIG][2*(p % PINS_PER_TRIG) +: 2];
        end
    end

    gpio_in_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) sync_i (
        .clk(clk), .rst_n(rst_n), .raw(pin_in),
        .level(pin_level), .level_prev(pin_level_prev)
    );

    gpio_edge_detect #(.NUM_PINS(NUM_PINS)) detect_i (
        .level(pin_level), .level_prev(pin_level_prev),
        .trig_codes(trig_codes), .evt(edge_evt)
    );

    // Sticky pending bits: a new edge outranks a same-cycle clear
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= (pend_q & ~pend_clr) | edge_evt;
    end

    // Return the addressed register, zero-extended
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFS_IDENT:   bus_rdata[7:0]          = {REV_MAJOR, REV_MINOR};
            OFS_PEND:    bus_rdata[NUM_PINS-1:0] = pend_q;
            OFS_IRQ_EN:  bus_rdata[NUM_PINS-1:0] = irq_en_q;
            OFS_WAKE_EN: bus_rdata[NUM_PINS-1:0] = wake_en_q;
            OFS_PIN_IN:  bus_rdata[NUM_PINS-1:0] = pin_level;
            OFS_DOUT:    bus_rdata[NUM_PINS-1:0] = dout_q;
            OFS_DIR:     bus_rdata[NUM_PINS-1:0] = dir_q;
            default: begin
                for (int w = 0; w < TRIG_WORDS; w++) begin
                    if (bus_addr == trig_ofs(w)) bus_rdata = trig_q[w];
                end
            end
        endcase
    end

    assign pin_out  = dout_q;
    assign pin_oe   = ~dir_q;
    assign bank_irq = |(pend_q & irq_en_q);
    assign wake_req = |(pend_q & wake_en_q);

endmodule

// File: rtl/gpio_edge_bank_chk.sv
// gpio_edge_bank_chk
// Property checker attached to gpio_edge_bank through bind. It watches the
// bus, the outputs, the detector events and the pending register.
// Assumes the same offsets as the package and a synchronous active-low reset.
module gpio_edge_bank_chk
    import gpio_edge_pkg::*;
#(
    parameter int NUM_PINS = 16
) (
    input logic                clk,
    input logic                rst_n,
    input logic [ADDR_W-1:0]   bus_addr,
    input logic                bus_wr,
    input logic [NUM_PINS-1:0] bus_wdata_lo,
    input logic [NUM_PINS-1:0] pin_out,
    input logic                bank_irq,
    input logic                wake_req,
    input logic [NUM_PINS-1:0] pend,
    input logic [NUM_PINS-1:0] evt
);

    logic past_ok;

    // Mark cycles whose previous cycle was already out of reset
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    a_r4_dout_set: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFS_DOUT_SET)
        |=> ((pin_out & $past(bus_wdata_lo)) == $past(bus_wdata_lo)));

    a_r4_dout_clr: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFS_DOUT_CLR)
        |=> ((pin_out & $past(bus_wdata_lo)) == '0));

    a_r8_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFS_PEND)
        |=> ((pend & $past(bus_wdata_lo) & ~$past(evt)) == '0));

    a_r9_edge_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt) |=> ((pend & $past(evt)) == $past(evt)));

    a_r6_only_events_set: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> ((pend & ~$past(pend) & ~$past(evt)) == '0));

    a_r10_irq_needs_pend: assert property (@(posedge clk) disable iff (!rst_n)
        bank_irq |-> (pend != '0));

    a_r11_wake_needs_pend: assert property (@(posedge clk) disable iff (!rst_n)
        wake_req |-> (pend != '0));

endmodule

bind gpio_edge_bank gpio_edge_bank_chk #(.NUM_PINS(NUM_PINS)) chk_i (
    .clk(clk),
    .rst_n(rst_n),
    .bus_addr(bus_addr),
    .bus_wr(bus_wr),
    .bus_wdata_lo(bus_wdata[NUM_PINS-1:0]),
    .pin_out(pin_out),
    .bank_irq(bank_irq),
    .wake_req(wake_req),
    .pend(pend_q),
    .evt(edge_evt)
);

// File: tb/gpio_edge_bank_tb_top.sv
`timescale 1ns/1ps
// gpio_edge_bank_tb_top
// Directed bench: one task per scenario. Inputs change on the falling
// clock edge and outputs are sampled there too.
module gpio_edge_bank_tb_top;
    import gpio_edge_pkg::*;

    localparam int WATCHDOG_CYC = 20000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [7:0]  bus_addr;
    logic        bus_wr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic [15:0] pin_in;
    logic [15:0] pin_out;
    logic [15:0] pin_oe;
    logic        bank_irq;
    logic        wake_req;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    gpio_edge_bank dut_i (
        .clk(clk), .rst_n(rst_n),
        .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
        .bank_irq(bank_irq), .wake_req(wake_req)
    );

    task automatic chk(input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Write one register: driven at a falling edge, taken at the next rising
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic rd(input string tag, input logic [7:0] a,
                      input logic [31:0] exp);
        bus_addr = a;
        #1;
        chk(tag, bus_rdata, exp);
    endtask

    task automatic t_reset();
        rd("R1 dir", OFS_DIR, 32'h0000_FFFF);
        rd("R1 dout", OFS_DOUT, 32'h0);
        rd("R1 irq_en", OFS_IRQ_EN, 32'h0);
        rd("R1 wake_en", OFS_WAKE_EN, 32'h0);
        rd("R1 pend", OFS_PEND, 32'h0);
        rd("R1 trig0", OFS_TRIG0, 32'h0);
        chk("R1 pins", {pin_oe, pin_out}, 32'h0);
        chk("R1 outs", {30'h0, bank_irq, wake_req}, 32'h0);
        rd("R2 ident", OFS_IDENT, 32'h0000_0021);
        wr(OFS_IDENT, 32'hFFFF_FFFF);
        rd("R2 ident read-only", OFS_IDENT, 32'h0000_0021);
    endtask

    task automatic t_dir_dout();
        wr(OFS_DIR, 32'h0000_00F0);
        chk("R3 oe", {16'h0, pin_oe}, 32'h0000_FF0F);
        wr(OFS_DOUT, 32'h0000_1234);
        chk("R3 out", {16'h0, pin_out}, 32'h0000_1234);
        wr(OFS_DOUT_SET, 32'h0000_0F00);
        chk("R4 set", {16'h0, pin_out}, 32'h0000_1F34);
        wr(OFS_DOUT_CLR, 32'h0000_0034);
        chk("R4 clr", {16'h0, pin_out}, 32'h0000_1F00);
    endtask

    task automatic t_enables();
        wr(OFS_IRQ_EN, 32'h0000_0011);
        wr(OFS_IRQ_SET, 32'h0000_0100);
        rd("R5 irq set", OFS_IRQ_EN, 32'h0000_0111);
        wr(OFS_IRQ_CLR, 32'h0000_0001);
        rd("R5 irq clr", OFS_IRQ_EN, 32'h0000_0110);
        wr(OFS_WAKE_SET, 32'h0000_8000);
        rd("R5 wake set", OFS_WAKE_EN, 32'h0000_8000);
        wr(OFS_WAKE_CLR, 32'h0000_8000);
        rd("R5 wake clr", OFS_WAKE_EN, 32'h0);
    endtask

    task automatic t_pin_level();
        pin_in = 16'hA5A5;
        @(negedge clk);
        rd("R7 one edge", OFS_PIN_IN, 32'h0);
        @(negedge clk);
        rd("R7 two edges", OFS_PIN_IN, 32'h0000_A5A5);
        pin_in = 16'h0000;
        repeat (3) @(negedge clk);
        rd("R6 code none", OFS_PEND, 32'h0);
    endtask

    task automatic t_trigger();
        // pin0 rise, pin1 fall, pin2 both, pin3 none; pin9 rise
        wr(OFS_TRIG0, 32'h0000_0036);
        wr(OFS_TRIG0 + 8'h04, 32'h0000_0008);
        rd("R6 trig hi readback", OFS_TRIG0 + 8'h04, 32'h0000_0008);
        pin_in = 16'h020F;
        repeat (3) @(negedge clk);
        rd("R6 rising", OFS_PEND, 32'h0000_0205);
        pin_in = 16'h0000;
        repeat (3) @(negedge clk);
        rd("R6 falling", OFS_PEND, 32'h0000_0207);
        chk("R10 pend masked", {31'h0, bank_irq}, 32'h0);
    endtask

    task automatic t_irq_wake();
        wr(OFS_IRQ_EN, 32'h0000_0004);
        chk("R10 irq on", {31'h0, bank_irq}, 32'h1);
        chk("R11 wake off", {31'h0, wake_req}, 32'h0);
        wr(OFS_WAKE_SET, 32'h0000_0200);
        chk("R11 wake on", {31'h0, wake_req}, 32'h1);
    endtask

    task automatic t_w1c();
        wr(OFS_PEND, 32'h0000_0004);
        rd("R8 clear one", OFS_PEND, 32'h0000_0203);
        chk("R10 irq drops", {31'h0, bank_irq}, 32'h0);
        wr(OFS_PEND, 32'h0);
        rd("R8 zero no effect", OFS_PEND, 32'h0000_0203);
        wr(OFS_PEND, 32'h0000_FFFF);
        rd("R8 clear all", OFS_PEND, 32'h0);
        chk("R11 wake drops", {31'h0, wake_req}, 32'h0);
    endtask

    task automatic t_set_wins();
        pin_in = 16'h0005;
        repeat (3) @(negedge clk);
        rd("R9 setup", OFS_PEND, 32'h0000_0005);
        pin_in = 16'h0001;           // pin2 falls, code both
        @(negedge clk);
        @(negedge clk);
        wr(OFS_PEND, 32'h0000_0005); // lands with the detected fall
        rd("R9 edge beats clear", OFS_PEND, 32'h0000_0004);
    endtask

    initial begin
        rst_n     = 1'b0;
        bus_addr  = '0;
        bus_wr    = 1'b0;
        bus_wdata = '0;
        pin_in    = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_dir_dout();
        t_enables();
        t_pin_level();
        t_trigger();
        t_irq_wake();
        t_w1c();
        t_set_wins();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #(WATCHDOG_CYC * 20);
        if (!done) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule